// File: doc/BRIEF.md
# PWM emergency shutdown controller

This block sits between a bank of PWM channel generators and the output pins. It samples an external fault input through a synchroniser, records every change of that input in an interrupt flag, and while the fault is asserted with shutdown enabled it drives every enabled channel output to a programmable safe level. The switch to the safe level happens in the same cycle the synchronised level goes active. The channel counters and duty logic sit outside; their raw outputs, enables and counter-zero strobes arrive as inputs.

After a fault, an enabled channel stays parked at the safe level until software releases it. Software can release it with a restart request, which counts only while the fault input is deasserted. It can also release it by clearing the shutdown enable. In both cases each channel returns to its raw waveform at its own next counter-zero strobe, so no channel restarts part-way through a period. Channels whose enable is low pass their raw signal through untouched.

Control sits in one 8-bit register. A write takes the whole byte, and the register can be read at any time.

Top module: `pwm_sd_top`

## Requirements
- R1: After reset the control register reads 0x00 and `irq` is 0. All fields are 0: flag bit7, interrupt enable bit6, restart bit5, safe level bit4, level status bit3, polarity bit2 and shutdown enable bit1. Bit0 always reads 0.
- R2: The flag (bit7) is set one cycle after any change of the synchronised fault level. A change from 0 to 1 sets it, and so does a change from 1 to 0.
- R3: Writing a byte with bit7 = 1 clears the flag. Writing bit7 = 0 leaves the flag unchanged. If a new edge arrives in the same cycle as the clear, the set wins.
- R4: `irq` is 1 exactly when both the flag (bit7) and the interrupt enable (bit6) are 1.
- R5: The fault counts as active when bit1 = 1 and the synchronised level equals bit2 (bit2 = 1 means active high, bit2 = 0 means active low). While the fault is active, every channel with `ch_en` high outputs the bit4 level. Channels with `ch_en` low always output `pwm_raw`.
- R6: The restart bit (bit5) always reads back as 0.
- R7: A restart request (write with bit5 = 1) made while the synchronised fault level is asserted is ignored. Channels held from that fault stay at the safe level through later counter-zero strobes.
- R8: After an accepted restart, each held channel returns to `pwm_raw` at its own next `ch_zero` strobe. A strobe in the same cycle as the restart write does not release the channel.
- R9: If bit1 is cleared while channels are held, each held channel returns to `pwm_raw` at its next `ch_zero` strobe, with no restart needed.
- R10: Bit3 reads the synchronised fault input level. The fault input passes through two flops before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register read value |
| fault_in | input | 1 | Asynchronous external fault input |
| ch_en | input | NCH | Per-channel enable |
| ch_zero | input | NCH | Per-channel counter-zero strobe |
| pwm_raw | input | NCH | Per-channel raw PWM output |
| pwm_out | output | NCH | Per-channel output toward the pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NCH = 3 and SYNC_STAGES = 2. It enables two channels and leaves the third disabled, so pass-through and forcing can be seen side by side in the same cycle. Having two enabled channels also lets the bench strobe counter-zero on one channel at a time, which shows that each channel releases independently after a restart. The bench covers both polarities and both safe levels. It also checks the flag on rising and falling fault edges, and shows that a restart written during an active fault is ignored.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;

    localparam int REG_W     = 8;
    localparam int B_FLAG    = 7;
    localparam int B_IE      = 6;
    localparam int B_RESTART = 5;
    localparam int B_LEVEL   = 4;
    localparam int B_STATUS  = 3;
    localparam int B_POL     = 2;
    localparam int B_ENA     = 1;

    typedef struct packed {
        logic flag;
        logic ie;
        logic level;
        logic pol;
        logic ena;
        logic prev;
    } ctrl_state_t;

    typedef struct packed {
        logic held;
        logic armed;
    } chan_state_t;

endpackage

// File: rtl/pwm_sd_sync.sv
module pwm_sd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_sd_ctrl.sv
module pwm_sd_ctrl
    import pwm_sd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             fault_lvl,
    output logic [REG_W-1:0] reg_rdata,
    output logic             fault_active,
    output logic             restart_ok,
    output logic             sd_enable,
    output logic             sd_level,
    output logic             irq
);

    ctrl_state_t st_d, st_q;
    logic        edge_seen;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[0], reg_wdata[B_STATUS]};

    always_comb begin
        st_d      = st_q;
        st_d.prev = fault_lvl;
        edge_seen = fault_lvl ^ st_q.prev;
        if (reg_we) begin
            st_d.ie    = reg_wdata[B_IE];
            st_d.level = reg_wdata[B_LEVEL];
            st_d.pol   = reg_wdata[B_POL];
            st_d.ena   = reg_wdata[B_ENA];
            if (reg_wdata[B_FLAG]) st_d.flag = 1'b0;
        end
        if (edge_seen) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_active = st_q.ena & (fault_lvl == st_q.pol);
    assign restart_ok   = reg_we & reg_wdata[B_RESTART] & (fault_lvl != st_q.pol);
    assign sd_enable    = st_q.ena;
    assign sd_level     = st_q.level;
    assign irq          = st_q.flag & st_q.ie;

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[B_FLAG]    = st_q.flag;
        reg_rdata[B_IE]      = st_q.ie;
        reg_rdata[B_LEVEL]   = st_q.level;
        reg_rdata[B_STATUS]  = fault_lvl;
        reg_rdata[B_POL]     = st_q.pol;
        reg_rdata[B_ENA]     = st_q.ena;
    end

endmodule

// File: rtl/pwm_sd_chan.sv
module pwm_sd_chan
    import pwm_sd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ch_en,
    input  logic ch_zero,
    input  logic raw,
    input  logic fault_active,
    input  logic restart_ok,
    input  logic sd_enable,
    input  logic sd_level,
    output logic out
);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ch_en) begin
            st_d = '0;
        end else if (fault_active) begin
            st_d.held  = 1'b1;
            st_d.armed = 1'b0;
        end else if (st_q.held) begin
            if (ch_zero && (st_q.armed || !sd_enable)) begin
                st_d = '0;
            end else if (restart_ok) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = (ch_en && (st_q.held || fault_active)) ? sd_level : raw;

endmodule

// File: rtl/pwm_sd_top.sv
module pwm_sd_top
    import pwm_sd_pkg::*;
#(
    parameter int NCH         = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             fault_in,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   ch_zero,
    input  logic [NCH-1:0]   pwm_raw,
    output logic [NCH-1:0]   pwm_out,
    output logic             irq
);

    logic fault_lvl;
    logic fault_active;
    logic restart_ok;
    logic sd_enable;
    logic sd_level;

    pwm_sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fault_in),
        .sync_out (fault_lvl)
    );

    pwm_sd_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .fault_lvl    (fault_lvl),
        .reg_rdata    (reg_rdata),
        .fault_active (fault_active),
        .restart_ok   (restart_ok),
        .sd_enable    (sd_enable),
        .sd_level     (sd_level),
        .irq          (irq)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            pwm_sd_chan u_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .ch_en        (ch_en[i]),
                .ch_zero      (ch_zero[i]),
                .raw          (pwm_raw[i]),
                .fault_active (fault_active),
                .restart_ok   (restart_ok),
                .sd_enable    (sd_enable),
                .sd_level     (sd_level),
                .out          (pwm_out[i])
            );
        end
    endgenerate

endmodule

// File: rtl/pwm_sd_chk.sv
module pwm_sd_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [7:0]     reg_wdata,
    input logic [7:0]     reg_rdata,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] pwm_raw,
    input logic [NCH-1:0] pwm_out,
    input logic           irq
);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (reg_rdata[7] && reg_rdata[6]));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !(reg_we && reg_wdata[7])) |=> reg_rdata[7]);

    // R2
    flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_rdata[3]) |=> reg_rdata[7]);

    // R5
    force_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && (reg_rdata[3] == reg_rdata[2]))
        |-> ((pwm_out & ch_en) == (ch_en & {NCH{reg_rdata[4]}})));

    // R5
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~ch_en) == (pwm_raw & ~ch_en));

endmodule

bind pwm_sd_top pwm_sd_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ch_en     (ch_en),
    .pwm_raw   (pwm_raw),
    .pwm_out   (pwm_out),
    .irq       (irq)
);

// File: tb/pwm_sd_top_tb.sv
module pwm_sd_top_tb;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic           fault_in = 1'b0;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] ch_zero = '0;
    logic [NCH-1:0] pwm_raw = '0;
    logic [NCH-1:0] pwm_out;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NCH-1:0] out;
        logic           irq;
        logic [7:0]     rdata;
        string          tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    pwm_sd_top #(.NCH(NCH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fault_in(fault_in), .ch_en(ch_en),
        .ch_zero(ch_zero), .pwm_raw(pwm_raw), .pwm_out(pwm_out), .irq(irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pwm_out !== e.out || irq !== e.irq || reg_rdata !== e.rdata) begin
                errors++;
                $display("FAIL %s: out=%b irq=%b rdata=%h expected out=%b irq=%b rdata=%h",
                         e.tag, pwm_out, irq, reg_rdata, e.out, e.irq, e.rdata);
            end
        end
    end

    task automatic expect_st(input logic [NCH-1:0] o, input logic i,
                             input logic [7:0] r, input string tag);
        exp_t e;
        e.out = o; e.irq = i; e.rdata = r; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d, input logic [NCH-1:0] z);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_wdata = d; ch_zero = z;
        @(posedge clk); #1;
        reg_we = 1'b0; ch_zero = '0;
    endtask

    task automatic zero_pulse(input logic [NCH-1:0] z);
        @(posedge clk); #1;
        ch_zero = z;
        @(posedge clk); #1;
        ch_zero = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: out=%b expected completion", pwm_out);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pwm_raw = 3'b101;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        expect_st(3'b101, 1'b0, 8'h00, "R1 reset state");

        ch_en = 3'b011; pwm_raw = 3'b000;
        wr(8'h76, '0);
        idle(1);
        expect_st(3'b000, 1'b0, 8'h56, "R6 restart bit reads 0");

        fault_in = 1'b1; idle(4);
        expect_st(3'b011, 1'b1, 8'hDE, "R5 R2 R4 R10 rising fault forces high");

        wr(8'h56, '0); idle(1);
        expect_st(3'b011, 1'b1, 8'hDE, "R3 write 0 keeps flag");

        wr(8'hD6, '0); idle(1);
        expect_st(3'b011, 1'b0, 8'h5E, "R3 R4 write 1 clears flag");

        wr(8'h76, '0);
        fault_in = 1'b0; idle(4);
        expect_st(3'b011, 1'b1, 8'hD6, "R7 R2 falling edge, restart ignored");
        zero_pulse(3'b011); idle(1);
        expect_st(3'b011, 1'b1, 8'hD6, "R7 held through zero strobe");

        wr(8'hD6, '0); idle(1);
        expect_st(3'b011, 1'b0, 8'h56, "R3 flag cleared");

        wr(8'h76, 3'b011); idle(1);
        expect_st(3'b011, 1'b0, 8'h56, "R8 same-cycle zero does not release");
        zero_pulse(3'b001); idle(1);
        expect_st(3'b010, 1'b0, 8'h56, "R8 channel 0 released alone");
        zero_pulse(3'b010); idle(1);
        expect_st(3'b000, 1'b0, 8'h56, "R8 channel 1 released");
        pwm_raw = 3'b111; idle(1);
        expect_st(3'b111, 1'b0, 8'h56, "R8 raw passes after release");

        wr(8'h46, '0);
        fault_in = 1'b1; idle(4);
        expect_st(3'b100, 1'b1, 8'hCE, "R5 safe level 0, disabled channel raw");
        wr(8'hC6, '0);
        fault_in = 1'b0; idle(4);
        expect_st(3'b100, 1'b1, 8'hC6, "R2 falling edge with channels held");
        wr(8'h84, '0); idle(1);
        expect_st(3'b100, 1'b0, 8'h04, "R9 held until zero after disable");
        zero_pulse(3'b011); idle(1);
        expect_st(3'b111, 1'b0, 8'h04, "R9 released on zero without restart");

        pwm_raw = 3'b000;
        fault_in = 1'b1; idle(4);
        wr(8'h92, '0); idle(1);
        expect_st(3'b000, 1'b0, 8'h1A, "R10 status high, active-low idle");
        fault_in = 1'b0; idle(4);
        expect_st(3'b011, 1'b0, 8'h92, "R5 R10 active-low fault forces high");

        idle(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule